// File: doc/BRIEF.md
# Segmented Scan Test Sequencer

This block sequences a two-pattern delay test on a scan chain that is cut into several equal segments. The segments share one serial input and one serial output. Each segment has its own gated clock, and each segment's output reaches the shared scan-out line only while that segment is selected. When started, the block shifts a test vector into the segments one segment at a time, in ascending order, with only that segment clocked. It then leaves scan mode for two consecutive functional clock edges. The first edge is the launch and the second is the capture. Each edge is applied only to the segments named in its own mask. Afterwards it unloads the segments in the same ascending order and raises a one-cycle done pulse.

Because launch and capture take separate masks, the second vector can be formed from a mix of sources. Launched segments contribute values produced by the logic under test. Segments that were not launched contribute the values that were shifted in. A segment that launches but does not capture keeps its launched value, and a segment in neither mask keeps the value that was loaded into it. With both masks all ones, the sequence behaves exactly like a single unsegmented chain run launch-on-capture. A request whose capture mask is all zero is refused: done is raised together with an error flag, and no clock enable is issued.

All outputs are registered, so each output vector appears one cycle after the internal state that produces it.

Top module: `segscan_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, every clock enable, every output select, scan_en, done and scan_err are 0.
- R2: Load starts two cycles after start is sampled. Segments 0 through NUM_SEG-1 are clocked in order, each for SEG_LEN consecutive cycles. Exactly one seg_clk_en bit is high in each of these cycles, and scan_en is 1.
- R3: seg_out_sel is always zero or one-hot. It equals seg_clk_en in every shift cycle and is zero outside shift cycles.
- R4: The cycle right after the last load cycle is the launch cycle: scan_en is 0 and seg_clk_en equals the launch mask that was sampled with start.
- R5: The cycle right after the launch cycle is the capture cycle: scan_en is 0 and seg_clk_en equals the capture mask that was sampled with start.
- R6: After capture, the segments are unloaded in the same order and with the same timing as in R2. The next cycle shows done=1 with scan_err=0 for exactly one cycle, and then every output returns to 0.
- R7: If start is sampled with an all-zero capture mask, the second cycle after it shows done=1 and scan_err=1 for one cycle, and no seg_clk_en bit rises.
- R8: A start pulse that arrives while a sequence is in progress, and the mask values present with it, are ignored.
- R9: With both masks all ones, the segment contents after capture equal two functional steps applied to the whole loaded chain.
- R10: A segment in the launch mask but not in the capture mask holds its launched value after capture. A capturing segment whose neighbour was launched computes its captured value from that neighbour's launched value.
- R11: A segment in neither mask receives no clock pulse between the end of its load and the start of unload, so it still holds its loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one load/launch/capture/unload sequence |
| launch_mask | input | NUM_SEG | Segments that receive the launch edge |
| capture_mask | input | NUM_SEG | Segments that receive the capture edge |
| seg_clk_en | output | NUM_SEG | Per-segment clock enable |
| seg_out_sel | output | NUM_SEG | Per-segment scan-out gate select |
| scan_en | output | 1 | 1 selects shift, 0 selects functional capture |
| done | output | 1 | One-cycle end-of-sequence pulse |
| scan_err | output | 1 | Set together with done when the request was refused |

## Verification
The bench builds the block with NUM_SEG=4 and SEG_LEN=6. With four segments, a launch segment and a separate capture segment can be chosen while another segment sits in neither mask, and the neighbour relation of the bench's functional logic wraps around the chain. Six cells per segment make the shift order and the segment boundaries visible in the content of every segment. The bench models the segment flip-flops and a small functional logic block driven by the controller's enables. It checks the post-capture contents against values computed from the pattern and the masks alone.

// File: rtl/segscan_pkg.sv
package segscan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD    = 3'd1,
    PH_LAUNCH  = 3'd2,
    PH_CAPTURE = 3'd3,
    PH_UNLOAD  = 3'd4,
    PH_DONE    = 3'd5
  } phase_t;
endpackage

// File: rtl/ssc_walker.sv
module ssc_walker #(
  parameter int NUM_SEG = 4,
  parameter int SEG_LEN = 8,
  localparam int SW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int BW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [SW-1:0] seg_idx,
  output logic          at_end
);
  logic [BW-1:0] bit_q;
  logic [SW-1:0] seg_q;
  logic          last_bit;
  logic          last_seg;

  assign last_bit = (bit_q == BW'(SEG_LEN - 1));
  assign last_seg = (seg_q == SW'(NUM_SEG - 1));
  assign at_end   = last_bit && last_seg;
  assign seg_idx  = seg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      seg_q <= '0;
    end else if (step) begin
      if (last_bit) begin
        bit_q <= '0;
        seg_q <= last_seg ? '0 : seg_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
  import segscan_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   cap_nonzero,
  input  logic   at_end,
  output phase_t phase,
  output logic   err_q,
  output logic   step,
  output logic   accept
);
  phase_t phase_q;

  assign phase  = phase_q;
  assign step   = (phase_q == PH_LOAD) || (phase_q == PH_UNLOAD);
  assign accept = (phase_q == PH_IDLE) && start && cap_nonzero;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= cap_nonzero ? PH_LOAD : PH_DONE;
            err_q   <= !cap_nonzero;
          end
        end
        PH_LOAD:    if (at_end) phase_q <= PH_LAUNCH;
        PH_LAUNCH:  phase_q <= PH_CAPTURE;
        PH_CAPTURE: phase_q <= PH_UNLOAD;
        PH_UNLOAD:  if (at_end) phase_q <= PH_DONE;
        PH_DONE: begin
          phase_q <= PH_IDLE;
          err_q   <= 1'b0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssc_out_decode.sv
module ssc_out_decode
  import segscan_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int SW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  phase_t             phase,
  input  logic [SW-1:0]      seg_idx,
  input  logic [NUM_SEG-1:0] launch_q,
  input  logic [NUM_SEG-1:0] capture_q,
  input  logic               err_q,
  output logic [NUM_SEG-1:0] clk_en_d,
  output logic [NUM_SEG-1:0] sel_d,
  output logic               scan_en_d,
  output logic               done_d,
  output logic               err_d
);
  logic [NUM_SEG-1:0] seg_oh;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_oh
    assign seg_oh[g] = (seg_idx == SW'(g));
  end

  always_comb begin
    clk_en_d  = '0;
    sel_d     = '0;
    scan_en_d = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    case (phase)
      PH_LOAD, PH_UNLOAD: begin
        clk_en_d  = seg_oh;
        sel_d     = seg_oh;
        scan_en_d = 1'b1;
      end
      PH_LAUNCH:  clk_en_d = launch_q;
      PH_CAPTURE: clk_en_d = capture_q;
      PH_DONE: begin
        done_d = 1'b1;
        err_d  = err_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/segscan_ctrl.sv
module segscan_ctrl
  import segscan_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_LEN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NUM_SEG-1:0] launch_mask,
  input  logic [NUM_SEG-1:0] capture_mask,
  output logic [NUM_SEG-1:0] seg_clk_en,
  output logic [NUM_SEG-1:0] seg_out_sel,
  output logic               scan_en,
  output logic               done,
  output logic               scan_err
);
  localparam int SW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  phase_t             phase;
  logic               err_q, step, accept, at_end;
  logic [SW-1:0]      seg_idx;
  logic [NUM_SEG-1:0] launch_q, capture_q;
  logic [NUM_SEG-1:0] clk_en_d, sel_d;
  logic               scan_en_d, done_d, err_d;

  ssc_walker #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN)) u_walker (
    .clk(clk), .rst(rst), .step(step), .seg_idx(seg_idx), .at_end(at_end)
  );

  ssc_sequencer u_seq (
    .clk(clk), .rst(rst), .start(start), .cap_nonzero(|capture_mask),
    .at_end(at_end), .phase(phase), .err_q(err_q), .step(step), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      launch_q  <= '0;
      capture_q <= '0;
    end else if (accept) begin
      launch_q  <= launch_mask;
      capture_q <= capture_mask;
    end
  end

  ssc_out_decode #(.NUM_SEG(NUM_SEG)) u_dec (
    .phase(phase), .seg_idx(seg_idx), .launch_q(launch_q), .capture_q(capture_q),
    .err_q(err_q), .clk_en_d(clk_en_d), .sel_d(sel_d), .scan_en_d(scan_en_d),
    .done_d(done_d), .err_d(err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_clk_en  <= '0;
      seg_out_sel <= '0;
      scan_en     <= 1'b0;
      done        <= 1'b0;
      scan_err    <= 1'b0;
    end else begin
      seg_clk_en  <= clk_en_d;
      seg_out_sel <= sel_d;
      scan_en     <= scan_en_d;
      done        <= done_d;
      scan_err    <= err_d;
    end
  end
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int NUM_SEG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SEG-1:0] seg_clk_en,
  input logic [NUM_SEG-1:0] seg_out_sel,
  input logic               scan_en,
  input logic               done,
  input logic               scan_err
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (seg_clk_en == '0 && seg_out_sel == '0 && !scan_en && !done && !scan_err));

  assert_single_shift_seg_R2: assert property (@(posedge clk) disable iff (rst)
    (scan_en && |seg_clk_en) |-> ($countones(seg_clk_en) == 1 && seg_clk_en == seg_out_sel));

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_out_sel) && (seg_out_sel == '0 || scan_en));

  assert_capture_follows_launch_R4: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && |seg_clk_en && $past(scan_en)) |=> (!scan_en && |seg_clk_en));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    scan_err |-> (done && seg_clk_en == '0 && !scan_en));
endmodule

bind segscan_ctrl ssc_checker #(.NUM_SEG(NUM_SEG)) u_ssc_checker (
  .clk(clk), .rst(rst), .seg_clk_en(seg_clk_en), .seg_out_sel(seg_out_sel),
  .scan_en(scan_en), .done(done), .scan_err(scan_err)
);

// File: tb/segscan_ctrl_bench.sv
module segscan_ctrl_bench;
  localparam int S = 4;
  localparam int L = 6;
  localparam int N_SEQ = 2 * S * L + 3;

  typedef logic [S-1:0][L-1:0] chain_t;
  typedef struct packed {
    logic [S-1:0] en;
    logic [S-1:0] sel;
    logic         se;
    logic         dn;
    logic         er;
  } ovec_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [S-1:0] launch_mask = '0;
  logic [S-1:0] capture_mask = '0;
  logic [S-1:0] seg_clk_en, seg_out_sel;
  logic         scan_en, done, scan_err;
  logic         scan_in = 1'b0;
  logic         scan_out;

  int checks = 0;
  int failures = 0;
  int done_seen = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  segscan_ctrl #(.NUM_SEG(S), .SEG_LEN(L)) u_segscan_ctrl (
    .clk(clk), .rst(rst), .start(start), .launch_mask(launch_mask),
    .capture_mask(capture_mask), .seg_clk_en(seg_clk_en), .seg_out_sel(seg_out_sel),
    .scan_en(scan_en), .done(done), .scan_err(scan_err)
  );

  function automatic chain_t func_next(input chain_t x);
    chain_t y;
    for (int k = 0; k < S; k++)
      y[k] = {x[k][L-2:0], x[k][L-1]} ^ x[(k + 1) % S] ^ L'(k + 1);
    return y;
  endfunction

  function automatic chain_t apply_edge(input chain_t x, input logic [S-1:0] m);
    chain_t f = func_next(x);
    chain_t y = x;
    for (int k = 0; k < S; k++) if (m[k]) y[k] = f[k];
    return y;
  endfunction

  // Segment flip-flops and the functional logic under test.
  chain_t segs = '0;
  always @(posedge clk) begin
    chain_t f;
    f = func_next(segs);
    for (int k = 0; k < S; k++)
      if (seg_clk_en[k])
        segs[k] <= scan_en ? {segs[k][L-2:0], scan_in} : f[k];
  end
  always_comb begin
    scan_out = 1'b0;
    for (int k = 0; k < S; k++) if (seg_out_sel[k]) scan_out = segs[k][L-1];
  end

  // Behavioural reference of the controller outputs.
  ovec_t  exp_q[$];
  string  tag_q[$];
  logic   bit_q[$];
  ovec_t  exp_now = '0;
  string  tag_now = "R1";
  chain_t cur_pat = '0;
  chain_t exp_chain = '0;
  logic   exp_valid = 1'b0;

  always @(posedge clk) begin
    bit was_empty;
    ovec_t v;
    if (rst) begin
      exp_q.delete(); tag_q.delete(); bit_q.delete();
      exp_now = '0; tag_now = "R1";
    end else begin
      was_empty = (exp_q.size() == 0);
      if (!was_empty) begin
        exp_now = exp_q.pop_front(); tag_now = tag_q.pop_front();
      end else begin
        exp_now = '0; tag_now = "R8";
      end
      if (was_empty && start) begin
        if (capture_mask == '0) begin
          v = '0; v.dn = 1'b1; v.er = 1'b1;
          exp_q.push_back(v); tag_q.push_back("R7");
        end else begin
          for (int k = 0; k < S; k++)
            for (int b = 0; b < L; b++) begin
              v = '0; v.en[k] = 1'b1; v.sel[k] = 1'b1; v.se = 1'b1;
              exp_q.push_back(v); tag_q.push_back("R2");
              bit_q.push_back(cur_pat[k][L-1-b]);
            end
          v = '0; v.en = launch_mask;  exp_q.push_back(v); tag_q.push_back("R4");
          v = '0; v.en = capture_mask; exp_q.push_back(v); tag_q.push_back("R5");
          for (int k = 0; k < S; k++)
            for (int b = 0; b < L; b++) begin
              v = '0; v.en[k] = 1'b1; v.sel[k] = 1'b1; v.se = 1'b1;
              exp_q.push_back(v); tag_q.push_back("R6");
            end
          v = '0; v.dn = 1'b1; exp_q.push_back(v); tag_q.push_back("R6");
          exp_chain = apply_edge(apply_edge(cur_pat, launch_mask), capture_mask);
          exp_valid = 1'b1;
        end
      end
    end
  end

  // Compare away from the active edge and drive scan-in.
  string  chain_tag = "R9";
  logic   in_func = 1'b0;
  always @(negedge clk) begin
    ovec_t got;
    cycles++;
    got = '{en: seg_clk_en, sel: seg_out_sel, se: scan_en, dn: done, er: scan_err};
    if (!rst) begin
      checks++;
      if (got !== exp_now) begin
        failures++;
        $display("FAIL %s cycle %0d: outputs actual=%h expected=%h", tag_now, cycles, got, exp_now);
      end
      if (done) done_seen++;
      if (scan_en && bit_q.size() != 0) scan_in <= bit_q.pop_front();
      else scan_in <= 1'b0;
      if (!scan_en && |seg_clk_en) in_func = 1'b1;
      else if (scan_en && in_func) begin
        in_func = 1'b0;
        checks++;
        if (!exp_valid || segs !== exp_chain || scan_out !== exp_chain[0][L-1]) begin
          failures++;
          $display("FAIL %s post-capture chain actual=%h expected=%h", chain_tag, segs, exp_chain);
        end
        exp_valid = 1'b0;
      end
    end
  end

  task automatic run_seq(input chain_t pat, input logic [S-1:0] lm,
                         input logic [S-1:0] cm, input string tag);
    @(negedge clk);
    cur_pat = pat; chain_tag = tag;
    launch_mask = lm; capture_mask = cm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N_SEQ + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (seg_clk_en !== '0 || seg_out_sel !== '0 || scan_en !== 1'b0 || done !== 1'b0 || scan_err !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b_%b_%b%b%b expected=0", seg_clk_en, seg_out_sel, scan_en, done, scan_err);
    end
    rst = 1'b0;
    @(negedge clk);

    // R10: launch in segment 0 only, capture in segment 3 whose neighbour is 0
    run_seq({6'h2d, 6'h13, 6'h3a, 6'h05}, 4'b0001, 4'b1000, "R10");
    // R9: whole chain behaves like an unsegmented chain
    run_seq({6'h11, 6'h2e, 6'h07, 6'h39}, 4'b1111, 4'b1111, "R9");
    // R11: segments 1 and 2 sit in neither mask
    run_seq({6'h3f, 6'h00, 6'h2a, 6'h15}, 4'b0001, 4'b1000, "R11");
    // R7: zero capture mask refused
    run_seq({6'h01, 6'h02, 6'h03, 6'h04}, 4'b1111, 4'b0000, "R7");
    // R5: capture differs from launch, capture mask sampled with start
    run_seq({6'h1c, 6'h23, 6'h30, 6'h0f}, 4'b0110, 4'b0011, "R5");

    // R8: a second start mid-sequence with other masks is ignored
    done_seen = 0;
    @(negedge clk);
    cur_pat = {6'h0a, 6'h35, 6'h1b, 6'h24}; chain_tag = "R8";
    launch_mask = 4'b0010; capture_mask = 4'b0100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    launch_mask = 4'b1111; capture_mask = 4'b0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; launch_mask = 4'b0010; capture_mask = 4'b0100;
    repeat (N_SEQ + 4) @(negedge clk);
    checks++;
    if (done_seen != 1) begin
      failures++;
      $display("FAIL R8 done pulses actual=%0d expected=1", done_seen);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule